// File: doc/BRIEF.md
# BCD Calendar Clock Register Window

This block keeps a full calendar and time of day in BCD. It shows that calendar as eight bytes at the top of a 13-bit byte address space. A prescaler outside the block supplies a one-cycle pulse once per second. The block uses that pulse to advance a set of hidden counters through seconds, minutes, 24-hour hours, day of week, date, month, two-digit year and a binary century. Month lengths and leap-year Februaries are handled on the fly.

Software does not see the counters directly. It sees a bank of holding registers. On every tick that is not blocked, these registers are overwritten with the new counter value. Two bits in a control byte govern that path:
- The freeze bit stops the copy, so that a multi-byte read is coherent while time keeps running.
- The halt bit stops the counters altogether. Software may then write the holding registers. Clearing halt moves those holding values into the counters, and counting starts again from them.

Accesses are synchronous: an address, a write strobe with data, and a registered read port.

Top module: `rtc_calendar_window`

## Requirements
- R1: Only addresses 1FF8h..1FFFh respond. Any other address reads 00h one cycle later, and a write to it changes no clock byte. Offsets within the window:
  - 0: control
  - 1: seconds
  - 2: minutes
  - 3: hours
  - 4: day/century
  - 5: date
  - 6: month
  - 7: year
- R2: After reset the window reads:
  - control 00h
  - time 00:00:00
  - day/century 01h
  - date 01h
  - month 01h
  - year 00h
- R3: Seconds and minutes count 00..59 in BCD, carrying from the units digit to the tens digit at 9. Hours count 00..23. Each wrap carries into the next field.
- R4: The day/century byte holds the day of week in bits 2:0, running 1..7 and returning to 1 when the hour wraps. It holds a binary century in bits 7:4, which increments when the year wraps from 99 to 00. Bit 3 always reads 0.
- R5: The date returns to 01 and the month advances:
  - after 30 in months 04, 06, 09 and 11;
  - after 31 in the other months.

  Month 12 wraps to 01 and advances the year.
- R6: February ends at 29 when the BCD year is a multiple of four, and at 28 otherwise.
- R7: A non-BCD value written to a field is kept as written. On its next increment:
  - a value at or above the field's last legal value wraps to the first legal value and carries;
  - a units digit of 9 or more rolls into the tens digit.
- R8: On a tick with neither halt nor freeze set, every time byte shows the advanced time from the clock cycle of that tick onward.
- R9: While control bit 6 (freeze) is 1, ticks leave the visible bytes unchanged but the counters keep advancing. After freeze is cleared, the next tick shows the up-to-date time.
- R10: While control bit 7 (halt) is 1, the counters do not advance and ticks do not overwrite the visible bytes. A control write that clears halt loads the visible bytes into the counters.
- R11: Control bits 5:0 store a calibration value that reads back unchanged. All reads return data on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe for the addressed byte |
| rdata | output | 8 | Registered read data |

## Verification
A table of preset times, each advanced by a single tick, exercises the rollover chain.

Some entries move only the seconds, which separates a plain increment from a digit carry. Others end at 23:59:59 on the last day of:
- 30-day months;
- 31-day months;
- leap Februaries;
- non-leap Februaries;
- a December 99.

These show that each carry goes exactly as far as it should.

Entries with non-BCD seconds separate the wrap-to-first rule from the digit-roll rule.

Directed sequences compare freeze against halt, where the first keeps the counters running and the second does not. They also separate window addresses from aliases outside the window.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;

  localparam int CLK_BYTES = 8;
  localparam int OFF_W     = $clog2(CLK_BYTES);

  localparam logic [7:0] SEC_LAST  = 8'h59;
  localparam logic [7:0] MIN_LAST  = 8'h59;
  localparam logic [7:0] HOUR_LAST = 8'h23;
  localparam logic [7:0] MON_LAST  = 8'h12;
  localparam logic [7:0] YEAR_LAST = 8'h99;
  localparam logic [2:0] DOW_LAST  = 3'd7;

  localparam int HALT_BIT   = 7;
  localparam int FREEZE_BIT = 6;

  typedef struct packed {
    logic [3:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [2:0] dow;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } rtc_time_t;

  // Byte 0 of the window is the control byte; time lives in 1..7.
  typedef logic [CLK_BYTES-1:1][7:0] clk_bytes_t;

  localparam rtc_time_t RESET_TIME = '{cent: 4'd0, year: 8'h00, month: 8'h01,
                                       date: 8'h01, dow: 3'd1, hour: 8'h00,
                                       minute: 8'h00, second: 8'h00};

  function automatic logic is_leap(input logic [7:0] yr);
    if (!yr[4]) is_leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        is_leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      month_last = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

  // Returns {carry, next}: wraps to first at/above last, else BCD increment.
  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] last,
                                          input logic [7:0] first);
    if (v >= last)           bcd_step = {1'b1, first};
    else if (v[3:0] >= 4'd9) bcd_step = {1'b0, v[7:4] + 4'd1, 4'd0};
    else                     bcd_step = {1'b0, v + 8'd1};
  endfunction

  function automatic clk_bytes_t to_bytes(input rtc_time_t t);
    clk_bytes_t b;
    b[1] = t.second;
    b[2] = t.minute;
    b[3] = t.hour;
    b[4] = {t.cent, 1'b0, t.dow};
    b[5] = t.date;
    b[6] = t.month;
    b[7] = t.year;
    return b;
  endfunction

  function automatic rtc_time_t from_bytes(input clk_bytes_t b);
    rtc_time_t t;
    t.second = b[1];
    t.minute = b[2];
    t.hour   = b[3];
    t.cent   = b[4][7:4];
    t.dow    = b[4][2:0];
    t.date   = b[5];
    t.month  = b[6];
    t.year   = b[7];
    return t;
  endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_win_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  output logic       halt,
  output logic       freeze,
  output logic       load_pulse
);

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= 8'h00;
    else if (wr_en) ctrl_q <= wr_data;
  end

  assign halt       = ctrl_q[HALT_BIT];
  assign freeze     = ctrl_q[FREEZE_BIT];
  // Falling edge of halt, caused by a control write, reloads the counters.
  assign load_pulse = wr_en && ctrl_q[HALT_BIT] && !wr_data[HALT_BIT];

endmodule

// File: rtl/rtc_count_chain.sv
module rtc_count_chain
  import rtc_win_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step_en,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cnt_q,
  output rtc_time_t cnt_nxt
);

  logic [8:0] s_sec, s_min, s_hour, s_date, s_mon, s_year;

  always_comb begin
    cnt_nxt = cnt_q;
    s_sec   = bcd_step(cnt_q.second, SEC_LAST, 8'h00);
    s_min   = bcd_step(cnt_q.minute, MIN_LAST, 8'h00);
    s_hour  = bcd_step(cnt_q.hour, HOUR_LAST, 8'h00);
    s_date  = bcd_step(cnt_q.date, month_last(cnt_q.month, cnt_q.year), 8'h01);
    s_mon   = bcd_step(cnt_q.month, MON_LAST, 8'h01);
    s_year  = bcd_step(cnt_q.year, YEAR_LAST, 8'h00);

    cnt_nxt.second = s_sec[7:0];
    if (s_sec[8]) begin
      cnt_nxt.minute = s_min[7:0];
      if (s_min[8]) begin
        cnt_nxt.hour = s_hour[7:0];
        if (s_hour[8]) begin
          cnt_nxt.dow  = (cnt_q.dow >= DOW_LAST) ? 3'd1 : cnt_q.dow + 3'd1;
          cnt_nxt.date = s_date[7:0];
          if (s_date[8]) begin
            cnt_nxt.month = s_mon[7:0];
            if (s_mon[8]) begin
              cnt_nxt.year = s_year[7:0];
              if (s_year[8]) cnt_nxt.cent = cnt_q.cent + 4'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= RESET_TIME;
    else if (load)    cnt_q <= load_val;
    else if (step_en) cnt_q <= cnt_nxt;
  end

  // R3: a stepped seconds field is always legal BCD
  a_r3_sec_legal: assert property (@(posedge clk) disable iff (rst)
    step_en && !load |=> (cnt_q.second <= SEC_LAST) && (cnt_q.second[3:0] <= 4'd9));

  // R6: leap February 28 at end of day steps to 29
  a_r6_leap_feb: assert property (@(posedge clk) disable iff (rst)
    step_en && !load && cnt_q.month == 8'h02 && cnt_q.date == 8'h28 &&
    cnt_q.hour == HOUR_LAST && cnt_q.minute == MIN_LAST && cnt_q.second == SEC_LAST &&
    is_leap(cnt_q.year) |=> cnt_q.date == 8'h29);

endmodule

// File: rtl/rtc_hold_bank.sv
module rtc_hold_bank
  import rtc_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             copy_en,
  input  clk_bytes_t       copy_val,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  output clk_bytes_t       hold_q
);

  localparam clk_bytes_t RESET_BYTES = to_bytes(RESET_TIME);

  logic [7:0] hold_r [1:CLK_BYTES-1];

  for (genvar i = 1; i < CLK_BYTES; i++) begin : g_byte
    // Bit 3 of the day/century byte is not stored.
    localparam logic [7:0] KEEP = (i == 4) ? 8'hF7 : 8'hFF;

    always_ff @(posedge clk) begin
      if (rst)                                     hold_r[i] <= RESET_BYTES[i];
      else if (wr_en && wr_sel == OFF_W'(i))       hold_r[i] <= wr_data & KEEP;
      else if (copy_en)                            hold_r[i] <= copy_val[i];
    end

    assign hold_q[i] = hold_r[i];
  end

endmodule

// File: rtl/rtc_calendar_window.sv
module rtc_calendar_window
  import rtc_win_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  output logic [7:0]        rdata
);

  logic             win_hit;
  logic [OFF_W-1:0] off;
  logic             wr_win, wr_ctrl, wr_time;
  logic [7:0]       ctrl_q;
  logic             halt, freeze, load_pulse;
  logic             step_en, copy_en;
  rtc_time_t        cnt_q, cnt_nxt;
  clk_bytes_t       hold_q;
  logic [7:0]       rd_mux;

  assign win_hit = &addr[ADDR_W-1:OFF_W];
  assign off     = addr[OFF_W-1:0];
  assign wr_win  = we && win_hit;
  assign wr_ctrl = wr_win && (off == '0);
  assign wr_time = wr_win && (off != '0);
  assign step_en = tick_1hz && !halt;
  assign copy_en = step_en && !freeze;

  rtc_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_ctrl),
    .wr_data    (wdata),
    .ctrl_q     (ctrl_q),
    .halt       (halt),
    .freeze     (freeze),
    .load_pulse (load_pulse)
  );

  rtc_count_chain u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .load     (load_pulse),
    .load_val (from_bytes(hold_q)),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt)
  );

  rtc_hold_bank u_hold (
    .clk      (clk),
    .rst      (rst),
    .copy_en  (copy_en),
    .copy_val (to_bytes(cnt_nxt)),
    .wr_en    (wr_time),
    .wr_sel   (off),
    .wr_data  (wdata),
    .hold_q   (hold_q)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (win_hit) begin
      if (off == '0) rd_mux = ctrl_q;
      else           rd_mux = hold_q[off];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_mux;
  end

  // R1: addresses outside the window read zero
  a_r1_outside_zero: assert property (@(posedge clk) disable iff (rst)
    !win_hit |=> rdata == 8'h00);

  // R8: an unblocked tick makes the visible bytes match the counters
  a_r8_copy_tracks: assert property (@(posedge clk) disable iff (rst)
    copy_en && !wr_time |=> hold_q == to_bytes(cnt_q));

  // R9: with freeze set and no write, visible bytes stay put
  a_r9_frozen_view: assert property (@(posedge clk) disable iff (rst)
    freeze && !wr_time |=> $stable(hold_q));

  // R10: with halt set and no reload, counters stay put
  a_r10_halted_count: assert property (@(posedge clk) disable iff (rst)
    halt && !load_pulse |=> $stable(cnt_q));

endmodule

// File: tb/tb_rtc_calendar_window.sv
`timescale 1ns/1ps
module tb_rtc_calendar_window;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_1hz;
  logic [12:0] addr;
  logic [7:0]  wdata;
  logic        we;
  logic [7:0]  rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;  // 250 MHz

  rtc_calendar_window dut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .addr(addr),
    .wdata(wdata), .we(we), .rdata(rdata)
  );

  localparam logic [12:0] WIN = 13'h1FF8;
  localparam int NV = 15;
  // {req[3:0], init{yr,mon,date,day,hr,min,sec}, expect{same}}
  localparam logic [115:0] VECS [NV] = '{
    {4'd3,  56'h24_03_15_13_08_10_05, 56'h24_03_15_13_08_10_06}, // R3 plain
    {4'd4,  56'h99_12_31_17_23_59_59, 56'h00_01_01_21_00_00_00}, // R4 century
    {4'd6,  56'h24_02_28_12_23_59_59, 56'h24_02_29_13_00_00_00}, // R6 leap
    {4'd6,  56'h23_02_28_12_23_59_59, 56'h23_03_01_13_00_00_00}, // R6 non-leap
    {4'd6,  56'h24_02_29_12_23_59_59, 56'h24_03_01_13_00_00_00}, // R6 leap end
    {4'd5,  56'h25_04_30_06_23_59_59, 56'h25_05_01_07_00_00_00}, // R5 30-day
    {4'd5,  56'h25_01_30_06_23_59_59, 56'h25_01_31_07_00_00_00}, // R5 31-day
    {4'd3,  56'h25_06_10_03_12_30_09, 56'h25_06_10_03_12_30_10}, // R3 digit carry
    {4'd7,  56'h25_06_10_03_12_30_3C, 56'h25_06_10_03_12_30_40}, // R7 digit roll
    {4'd7,  56'h25_06_10_03_12_10_5A, 56'h25_06_10_03_12_11_00}, // R7 wrap
    {4'd3,  56'h25_06_10_03_19_59_59, 56'h25_06_10_03_20_00_00}, // R3 hour carry
    {4'd5,  56'h19_12_31_05_23_59_59, 56'h20_01_01_06_00_00_00}, // R5 new year
    {4'd6,  56'h96_02_28_05_23_59_59, 56'h96_02_29_06_00_00_00}, // R6 odd tens
    {4'd4,  56'h25_09_30_37_23_59_59, 56'h25_10_01_31_00_00_00}, // R4 dow wrap
    {4'd4,  56'h25_06_15_1F_10_00_00, 56'h25_06_15_17_10_00_01}  // R4 bit3 masked
  };

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; we = 1'b0;
    @(posedge clk); #1 v = rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R0 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; tick_1hz = 1'b0; addr = '0; wdata = '0; we = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2: reset values
    rd(WIN + 0, v); chk("R2", "ctrl", v, 8'h00);
    rd(WIN + 1, v); chk("R2", "sec", v, 8'h00);
    rd(WIN + 3, v); chk("R2", "hour", v, 8'h00);
    rd(WIN + 4, v); chk("R2", "day", v, 8'h01);
    rd(WIN + 5, v); chk("R2", "date", v, 8'h01);
    rd(WIN + 6, v); chk("R2", "month", v, 8'h01);
    rd(WIN + 7, v); chk("R2", "year", v, 8'h00);

    // R9: freeze keeps view, counters run on
    wr(WIN + 0, 8'h40);
    tick();
    rd(WIN + 1, v); chk("R9", "frozen sec", v, 8'h00);
    wr(WIN + 0, 8'h00);
    tick();
    rd(WIN + 1, v); chk("R9", "unfrozen sec", v, 8'h02);
    // R8: plain tick updates view
    tick();
    rd(WIN + 1, v); chk("R8", "tick sec", v, 8'h03);

    // R10: halt stops counting and ticks do not overwrite
    wr(WIN + 0, 8'h80);
    tick();
    rd(WIN + 1, v); chk("R10", "halted sec", v, 8'h03);
    wr(WIN + 1, 8'h30);
    tick();
    rd(WIN + 1, v); chk("R10", "edited sec kept", v, 8'h30);
    wr(WIN + 0, 8'h00);
    rd(WIN + 1, v); chk("R10", "after release", v, 8'h30);
    tick();
    rd(WIN + 1, v); chk("R10", "loaded then step", v, 8'h31);

    // R11: calibration bits read back
    wr(WIN + 0, 8'h15);
    rd(WIN + 0, v); chk("R11", "calib", v, 8'h15);
    wr(WIN + 0, 8'h00);

    // R1: outside-window alias ignored and reads zero
    wr(13'h0FF9, 8'h55);
    rd(WIN + 1, v); chk("R1", "sec after alias write", v, 8'h31);
    rd(13'h0FF9, v); chk("R1", "outside read", v, 8'h00);

    // Vector table: preset under halt, release, one tick, compare
    for (int k = 0; k < NV; k++) begin
      logic [55:0] ini, ex;
      string tag;
      ini = VECS[k][111:56];
      ex  = VECS[k][55:0];
      tag = $sformatf("R%0d", VECS[k][115:112]);
      wr(WIN + 0, 8'h80);
      for (int b = 0; b < 7; b++) wr(WIN + 13'(b + 1), ini[8*b +: 8]);
      wr(WIN + 0, 8'h00);
      tick();
      for (int b = 0; b < 7; b++) begin
        rd(WIN + 13'(b + 1), v);
        chk(tag, $sformatf("vec %0d byte %0d", k, b + 1), v, ex[8*b +: 8]);
      end
    end

    finish_run();
  end

endmodule